// File: doc/BRIEF.md
# Palette RAMDAC Register Interface

This block is a colour lookup table with a small register interface. It holds a table of palette entries, and each entry has its own red, green and blue byte. A host writes 32-bit words into a 16-byte register window. It first selects an entry with an index register. It then loads the colour through a single data register. Each data write fills the next component in the order red, green, blue. After blue, the index moves on by itself, so a host can load a run of consecutive entries with one index write followed by a stream of data writes.

Display logic reads the table through a separate lookup port. It presents an entry number and gets the packed colour one clock later. Every time an entry is modified, a one-cycle update pulse is raised so that downstream logic can schedule a screen refresh. Register reads always return zero.

Top module: `pal_ramdac`

## Requirements
- R1: A bus write is accepted only when `bus_sel` and `bus_we` are high and all four byte enables are set (`bus_be` = 4'b1111). A write with any other byte-enable pattern has no effect on entries, index, step or the update pulse.
- R2: An accepted write at byte offset 0x0 sets the index to `bus_wdata[31:24]` modulo the entry count, and returns the component step to red.
- R3: Successive accepted writes at byte offset 0x4 store `bus_wdata[31:24]` into the red, then the green, then the blue byte of the entry selected by the index. Bits 23:0 of the write data are ignored.
- R4: The write that stores blue also advances the index by one modulo the entry count (the last entry wraps to entry 0), and the step returns to red.
- R5: `bus_rdata` is zero in every cycle, including cycles with a read access (`bus_sel` high, `bus_we` low).
- R6: Accepted writes at any offset other than 0x0 and 0x4 (for example 0x1, 0x8, 0xC), reads, and cycles with `bus_sel` low leave the entries, the index and the step unchanged.
- R7: After reset, every entry is black (0x000000) except the last entry, which is white (0xFFFFFF). The index is 0 and the step is red.
- R8: `lk_rgb` returns {red[23:16], green[15:8], blue[7:0]} of entry `lk_idx` as sampled at the previous rising clock edge (one cycle of latency).
- R9: `upd_pulse` is high for exactly the one cycle after each accepted offset-0x4 write, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe for this register window |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; only all-ones is accepted |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_wdata | input | 32 | Write data; the top byte carries index or component |
| bus_rdata | output | 32 | Read data, always zero |
| lk_idx | input | IDX_W | Lookup entry number |
| lk_rgb | output | 24 | Registered colour of the looked-up entry |
| upd_pulse | output | 1 | One-cycle pulse after an entry was modified |

## Verification
The bench builds the block with a 16-entry table (`IDX_W` = 4). At this size, the whole table can be checked after reset and after every phase, and one full stream of data writes can load all entries and then run past the last entry to show the wrap to entry 0. The reduced index width also exercises the modulo reduction of the index byte: 0x13 selects entry 3. Ignored offsets, partial byte enables, reads and deselected cycles are interleaved inside a red/green/blue sequence. The next data writes then show that the step and index were left untouched.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Component step of the colour loader
    typedef enum logic [1:0] {
        STEP_R = 2'd0,
        STEP_G = 2'd1,
        STEP_B = 2'd2
    } step_e;

    // Byte offsets inside the register window
    localparam logic [3:0] OFS_INDEX = 4'h0;
    localparam logic [3:0] OFS_DATA  = 4'h4;

endpackage

// File: rtl/pal_decode.sv
module pal_decode #(
    parameter int ADDR_W = 4,
    parameter int BE_W   = 4
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              set_idx,
    output logic              put_comp
);
    import pal_pkg::*;

    logic full_wr;

    always_comb begin
        full_wr  = bus_sel && bus_we && (bus_be == {BE_W{1'b1}});
        set_idx  = full_wr && (bus_addr == ADDR_W'(OFS_INDEX));
        put_comp = full_wr && (bus_addr == ADDR_W'(OFS_DATA));
    end

endmodule

// File: rtl/pal_seq.sv
module pal_seq #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_idx,
    input  logic             put_comp,
    input  logic [IDX_W-1:0] idx_val,
    output logic [IDX_W-1:0] cur_idx,
    output pal_pkg::step_e   cur_step,
    output logic             wr_en,
    output logic             upd_pulse
);
    import pal_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        step_e            step;
        logic             upd;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.upd = 1'b0;
        if (set_idx) begin
            s_d.idx  = idx_val;
            s_d.step = STEP_R;
        end else if (put_comp) begin
            s_d.upd = 1'b1;
            case (s_q.step)
                STEP_R:  s_d.step = STEP_G;
                STEP_G:  s_d.step = STEP_B;
                STEP_B: begin
                    s_d.step = STEP_R;
                    s_d.idx  = s_q.idx + IDX_W'(1);
                end
                default: s_d.step = STEP_R;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{idx: '0, step: STEP_R, upd: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_idx   = s_q.idx;
    assign cur_step  = s_q.step;
    assign wr_en     = put_comp;
    assign upd_pulse = s_q.upd;

endmodule

// File: rtl/pal_store.sv
module pal_store #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  pal_pkg::step_e      wr_step,
    input  logic [COMP_W-1:0]   wr_val,
    input  logic [IDX_W-1:0]    lk_idx,
    output logic [3*COMP_W-1:0] lk_rgb
);
    import pal_pkg::*;

    localparam int NUM   = 2 ** IDX_W;
    localparam int ENT_W = 3 * COMP_W;

    logic [ENT_W-1:0] ent_all [NUM];

    for (genvar e = 0; e < NUM; e++) begin : g_ent
        localparam logic [ENT_W-1:0] RST_VAL =
            (e == NUM - 1) ? {ENT_W{1'b1}} : {ENT_W{1'b0}};

        logic [ENT_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IDX_W'(e))) begin
                case (wr_step)
                    STEP_R:  ent_d[ENT_W-1 -: COMP_W]    = wr_val;
                    STEP_G:  ent_d[2*COMP_W-1 -: COMP_W] = wr_val;
                    STEP_B:  ent_d[COMP_W-1:0]           = wr_val;
                    default: ent_d = ent_q;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= RST_VAL;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_all[e] = ent_q;
    end

    logic [ENT_W-1:0] look_d, look_q;

    always_comb begin
        look_d = ent_all[lk_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            look_q <= '0;
        end else begin
            look_q <= look_d;
        end
    end

    assign lk_rgb = look_q;

endmodule

// File: rtl/pal_ramdac.sv
module pal_ramdac #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [BUS_W/8-1:0]  bus_be,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [IDX_W-1:0]    lk_idx,
    output logic [3*COMP_W-1:0] lk_rgb,
    output logic                upd_pulse
);
    import pal_pkg::*;

    localparam int BE_W = BUS_W / 8;

    logic              set_idx;
    logic              put_comp;
    logic              wr_en;
    logic [COMP_W-1:0] top_byte;
    logic [IDX_W-1:0]  cur_idx;
    step_e             cur_step;
    logic              unused_low;

    // Index and component both travel in the most significant byte
    assign top_byte   = bus_wdata[BUS_W-1 -: COMP_W];
    assign unused_low = ^bus_wdata[BUS_W-COMP_W-1:0];
    assign bus_rdata  = '0;

    pal_decode #(
        .ADDR_W (ADDR_W),
        .BE_W   (BE_W)
    ) u_decode (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_be   (bus_be),
        .bus_addr (bus_addr),
        .set_idx  (set_idx),
        .put_comp (put_comp)
    );

    pal_seq #(
        .IDX_W (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_idx   (set_idx),
        .put_comp  (put_comp),
        .idx_val   (top_byte[IDX_W-1:0]),
        .cur_idx   (cur_idx),
        .cur_step  (cur_step),
        .wr_en     (wr_en),
        .upd_pulse (upd_pulse)
    );

    pal_store #(
        .IDX_W  (IDX_W),
        .COMP_W (COMP_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (cur_idx),
        .wr_step (cur_step),
        .wr_val  (top_byte),
        .lk_idx  (lk_idx),
        .lk_rgb  (lk_rgb)
    );

endmodule

// File: rtl/pal_ramdac_chk.sv
module pal_ramdac_chk #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [BUS_W/8-1:0] bus_be,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [BUS_W-1:0]   bus_wdata,
    input logic [BUS_W-1:0]   bus_rdata,
    input logic               upd_pulse,
    input logic [IDX_W-1:0]   cur_idx,
    input logic [1:0]         cur_step
);
    logic             acc;
    logic             idx_wr;
    logic             dat_wr;
    logic [IDX_W-1:0] new_idx;

    assign acc     = bus_sel && bus_we && (&bus_be);
    assign idx_wr  = acc && (bus_addr == ADDR_W'(0));
    assign dat_wr  = acc && (bus_addr == ADDR_W'(4));
    assign new_idx = bus_wdata[BUS_W-COMP_W +: IDX_W];

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (cur_step == 2'd0) && (cur_idx == $past(new_idx)));

    // R3
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && cur_step != 2'd2) |=>
            (cur_step == 2'($past(cur_step) + 2'd1)) && $stable(cur_idx));

    // R4
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && cur_step == 2'd2) |=>
            (cur_step == 2'd0) && (cur_idx == IDX_W'($past(cur_idx) + IDX_W'(1))));

    // R6
    ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_wr || dat_wr) |=> $stable(cur_idx) && $stable(cur_step));

    // R9
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> $past(dat_wr));

    // R9
    pulse_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr |=> upd_pulse);

    // R5
    rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata == '0);

endmodule

bind pal_ramdac pal_ramdac_chk #(
    .IDX_W  (IDX_W),
    .COMP_W (COMP_W),
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .upd_pulse (upd_pulse),
    .cur_idx   (cur_idx),
    .cur_step  (cur_step)
);

// File: tb/pal_ramdac_tb.sv
`timescale 1ns/1ps
module pal_ramdac_tb;

    localparam int IDX_W = 4;
    localparam int NUM   = 2 ** IDX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = 4'h0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [IDX_W-1:0] lk_idx = '0;
    logic [23:0] lk_rgb;
    logic        upd_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the table, index and step
    logic [7:0] m_r [NUM];
    logic [7:0] m_g [NUM];
    logic [7:0] m_b [NUM];
    int m_idx;
    int m_step;

    always #5 clk = ~clk;

    pal_ramdac #(.IDX_W(IDX_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_be    (bus_be),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lk_idx    (lk_idx),
        .lk_rgb    (lk_rgb),
        .upd_pulse (upd_pulse)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NUM; i++) begin
            m_r[i] = (i == NUM - 1) ? 8'hFF : 8'h00;
            m_g[i] = (i == NUM - 1) ? 8'hFF : 8'h00;
            m_b[i] = (i == NUM - 1) ? 8'hFF : 8'h00;
        end
        m_idx  = 0;
        m_step = 0;
    endtask

    // One bus access; checks the pulse after the edge and its fall one cycle later
    task automatic access(input logic sel_i, input logic we_i, input logic [3:0] a,
                          input logic [7:0] v, input logic [3:0] be);
        bit acc, dw, iw;
        @(negedge clk);
        bus_sel   = sel_i;
        bus_we    = we_i;
        bus_addr  = a;
        bus_be    = be;
        bus_wdata = {v, 24'hA5C37E};
        acc = sel_i && we_i && (be == 4'hF);
        iw  = acc && (a == 4'h0);
        dw  = acc && (a == 4'h4);
        @(posedge clk);
        #1;
        check(upd_pulse == dw, "R9 pulse after access", 32'(upd_pulse), 32'(dw));
        check(bus_rdata == 32'h0, "R5 read data zero", bus_rdata, 32'h0);
        if (iw) begin
            m_idx  = int'(v) % NUM;
            m_step = 0;
        end else if (dw) begin
            case (m_step)
                0: m_r[m_idx] = v;
                1: m_g[m_idx] = v;
                default: m_b[m_idx] = v;
            endcase
            if (m_step == 2) begin
                m_step = 0;
                m_idx  = (m_idx + 1) % NUM;
            end else begin
                m_step++;
            end
        end
        @(negedge clk);
        bus_sel = 1'b0;
        bus_we  = 1'b0;
        bus_be  = 4'h0;
        @(posedge clk);
        #1;
        check(upd_pulse == 1'b0, "R9 pulse single cycle", 32'(upd_pulse), 32'h0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        access(1'b1, 1'b1, a, v, 4'hF);
    endtask

    task automatic look(input int i, input string req);
        logic [23:0] exp;
        @(negedge clk);
        lk_idx = IDX_W'(i);
        @(posedge clk);
        #1;
        exp = {m_r[i], m_g[i], m_b[i]};
        check(lk_rgb == exp, req, 32'(lk_rgb), 32'(exp));
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < NUM; i++) look(i, req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] held;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: reset contents, last entry white
        sweep("R7 reset contents");
        check(upd_pulse == 1'b0, "R7 no pulse after reset", 32'(upd_pulse), 32'h0);

        // R7: index 0 and step red after reset -> red of entry 0
        wr(4'h4, 8'h3C);
        look(0, "R7 first data write hits entry 0 red");

        // R2/R3/R4: load all entries from index 0 and wrap past the end
        wr(4'h0, 8'h00);
        for (int i = 0; i < NUM; i++) begin
            wr(4'h4, 8'(i * 7 + 1));
            wr(4'h4, 8'(i * 11 + 2));
            wr(4'h4, 8'(255 - i * 3));
        end
        sweep("R3 full table load");
        check(m_idx == 0, "R4 model wrapped", 32'(m_idx), 32'h0);
        wr(4'h4, 8'hE1);
        wr(4'h4, 8'hE2);
        wr(4'h4, 8'hE3);
        look(0, "R4 wrap from last entry to entry 0");
        look(1, "R4 entry 1 untouched after wrap");

        // R2: index byte reduced modulo entry count (0x13 -> 3)
        wr(4'h0, 8'h13);
        wr(4'h4, 8'h44);
        wr(4'h4, 8'h55);
        wr(4'h4, 8'h66);
        look(3, "R2 index modulo entry count");

        // R2: index write mid-sequence restarts at red
        wr(4'h0, 8'h05);
        wr(4'h4, 8'h11);
        wr(4'h0, 8'h05);
        wr(4'h4, 8'h22);
        wr(4'h4, 8'h33);
        look(5, "R2 step reset to red");

        // R1/R6: ignored accesses interleaved inside a sequence
        wr(4'h0, 8'h09);
        wr(4'h4, 8'h90);
        access(1'b1, 1'b1, 4'h8, 8'hBB, 4'hF);   // R6 offset 8
        access(1'b1, 1'b1, 4'hC, 8'hBB, 4'hF);   // R6 offset 12
        access(1'b1, 1'b1, 4'h1, 8'hBB, 4'hF);   // R6 offset 1
        access(1'b1, 1'b1, 4'h4, 8'hBB, 4'h7);   // R1 partial enables
        access(1'b1, 1'b1, 4'h0, 8'h02, 4'hE);   // R1 partial enables on index
        access(1'b1, 1'b0, 4'h4, 8'hBB, 4'hF);   // R6/R5 read access
        access(1'b0, 1'b1, 4'h4, 8'hBB, 4'hF);   // R6 not selected
        sweep("R6 ignored accesses leave table");
        wr(4'h4, 8'h91);
        wr(4'h4, 8'h92);
        look(9, "R6 step and index kept");
        wr(4'h4, 8'hA0);
        look(10, "R6 index advanced normally");

        // R8: one cycle of lookup latency
        look(9, "R8 lookup entry 9");
        held = lk_rgb;
        @(negedge clk);
        lk_idx = IDX_W'(10);
        #1;
        check(lk_rgb == held, "R8 output holds until edge", 32'(lk_rgb), 32'(held));
        @(posedge clk);
        #1;
        check(lk_rgb == {m_r[10], m_g[10], m_b[10]}, "R8 output after edge",
              32'(lk_rgb), 32'({m_r[10], m_g[10], m_b[10]}));

        // R7: reset again restores contents
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        sweep("R7 second reset contents");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule